// File: doc/BRIEF.md
# SMI Trigger with Feature Negotiation

This block watches a power-management command port. Each write to the port carries a command byte and the index of the processor that issued it. Two reserved command codes turn ACPI mode on or off and never raise a system management interrupt (SMI). Every other code raises an SMI, but only when the command-port enable bit of the SMI enable register is set. The SMI goes either to the issuing processor alone or to all processors. The choice depends on a feature set that firmware negotiates.

Negotiation works as follows. The host drives a 64-bit mask of the features it supports. Firmware fills a 64-bit request mask one byte at a time and then pulses a confirm strobe. If the request asks only for supported features, it is copied into the negotiated register and the status goes high. From then on the features stay locked until reset. Otherwise the request is refused and nothing changes.

A power-management control register holds a lock bit. Once software sets it, the lock bit and the command-port enable bit stay frozen until reset.

Top module: `smi_gate`

## Requirements
- R1: A command write of the enable code (8'hF1) gives a one-cycle `acpi_on_pulse` and sets `acpi_mode`. A write of the disable code (8'hF0) gives a one-cycle `acpi_off_pulse` and clears `acpi_mode`. Neither code raises any SMI, whatever the SMI enable register holds.
- R2: A command write of any other code raises an SMI only while bit 0 of `smi_en_q` is 1. The other bits of that register have no effect on this.
- R3: While bit 0 of `feat_neg` (the broadcast feature) is 0, an SMI sets only bit `cmd_src` of `smi_req`.
- R4: While bit 0 of `feat_neg` is 1, an SMI sets every bit of `smi_req`.
- R5: A confirm strobe whose request mask holds any bit that is clear in `host_feat` is refused: `feat_ok` stays 0 and `feat_neg` stays unchanged.
- R6: A confirm strobe whose request mask is a subset of `host_feat` takes effect on the next cycle: `feat_neg` takes the request and `feat_ok` becomes 1.
- R7: Once `feat_ok` is 1, later confirm strobes and request writes leave `feat_ok` and `feat_neg` unchanged until reset.
- R8: A request write with `req_addr` = k sets bits 8k+7..8k of the request mask. Address 0 holds the least significant byte.
- R9: Reset clears all of the following to 0: the request mask, `feat_ok`, `feat_neg`, `smi_en_q`, `pmcon_q`, `acpi_mode`, `smi_req` and both pulses.
- R10: Once bit 4 of `pmcon_q` (the lock) is 1, writes leave that bit and bit 0 of `smi_en_q` unchanged until reset. Writes still update the other bits of both registers.
- R11: `smi_req` and both ACPI pulses are registered. They appear in the cycle after the command write, last exactly one cycle, and stay 0 in any cycle that follows no command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command port write strobe |
| cmd_data | input | 8 | Command byte |
| cmd_src | input | SRC_W | Index of the issuing processor |
| host_feat | input | FEAT_W | Host-supported feature mask |
| req_we | input | 1 | Request mask byte write strobe |
| req_addr | input | BA_W | Byte index into the request mask |
| req_data | input | 8 | Request mask byte |
| confirm_stb | input | 1 | Negotiation confirm strobe |
| en_we | input | 1 | SMI enable register write strobe |
| en_wdata | input | EN_W | SMI enable register write data |
| pm_we | input | 1 | PM control register write strobe |
| pm_wdata | input | PM_W | PM control register write data |
| smi_en_q | output | EN_W | SMI enable register contents |
| pmcon_q | output | PM_W | PM control register contents |
| acpi_on_pulse | output | 1 | One-cycle pulse on the ACPI enable command |
| acpi_off_pulse | output | 1 | One-cycle pulse on the ACPI disable command |
| acpi_mode | output | 1 | Current ACPI mode |
| smi_req | output | NCPU | Per-processor SMI request, one cycle wide |
| feat_ok | output | 1 | Negotiation accepted and locked |
| feat_neg | output | FEAT_W | Negotiated feature set |

## Verification
A wrong negotiated set shows up at the first SMI-raising command write after confirmation. `smi_req` then comes out one-hot where all ones was expected, or the reverse, one cycle after the write. A missed or leaky lock, on either the feature status or the PM lock bit, shows on the register outputs in the cycle after the offending write. A request mask that reset failed to clear shows as a refused confirmation against an empty host mask. A misordered byte lane shows as a wrong `feat_neg` value one cycle after the confirm strobe.

// File: rtl/smi_gate_pkg.sv
package smi_gate_pkg;
  // SMI dispatch kinds for a single command write
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ON   = 2'd1,
    CMD_OFF  = 2'd2,
    CMD_SMI  = 2'd3
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic we, input logic [7:0] code,
                                         input logic [7:0] on_code,
                                         input logic [7:0] off_code);
    if (!we)                  return CMD_NONE;
    else if (code == on_code)  return CMD_ON;
    else if (code == off_code) return CMD_OFF;
    else                       return CMD_SMI;
  endfunction
endpackage

// File: rtl/smi_feat_negot.sv
module smi_feat_negot #(
  parameter int FEAT_W = 64,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_we,
  input  logic [BA_W-1:0]   req_addr,
  input  logic [7:0]        req_data,
  input  logic              confirm,
  input  logic [FEAT_W-1:0] host_feat,
  output logic              feat_ok,
  output logic [FEAT_W-1:0] feat_neg
);
  localparam int NB = FEAT_W / 8;

  logic [FEAT_W-1:0] req_q, req_d, neg_d;
  logic              ok_d, legal, accept;

  // byte lanes, address 0 is least significant
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign req_d[b*8 +: 8] = (req_addr == BA_W'(b)) ? req_data : req_q[b*8 +: 8];
  end

  assign legal  = ~|(req_q & ~host_feat);
  assign accept = confirm && !feat_ok && legal;

  always_comb begin
    ok_d  = feat_ok;
    neg_d = feat_neg;
    if (accept) begin
      ok_d  = 1'b1;
      neg_d = req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (req_we) begin
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_ok  <= 1'b0;
      feat_neg <= '0;
    end else if (accept) begin
      feat_ok  <= ok_d;
      feat_neg <= neg_d;
    end
  end
endmodule

// File: rtl/smi_ctl_regs.sv
module smi_ctl_regs #(
  parameter int EN_W     = 8,
  parameter int PM_W     = 8,
  parameter int LOCK_BIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic [EN_W-1:0] en_wdata,
  input  logic            pm_we,
  input  logic [PM_W-1:0] pm_wdata,
  output logic [EN_W-1:0] en_q,
  output logic [PM_W-1:0] pm_q
);
  logic [EN_W-1:0] en_d;
  logic [PM_W-1:0] pm_d;
  logic            locked;

  assign locked = pm_q[LOCK_BIT];

  always_comb begin
    en_d = en_wdata;
    if (locked) en_d[0] = en_q[0];
  end

  always_comb begin
    pm_d = pm_wdata;
    if (locked) pm_d[LOCK_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q <= '0;
    end else if (pm_we) begin
      pm_q <= pm_d;
    end
  end
endmodule

// File: rtl/smi_dispatch.sv
module smi_dispatch
  import smi_gate_pkg::*;
#(
  parameter int         NCPU     = 4,
  parameter int         SRC_W    = 2,
  parameter logic [7:0] CODE_ON  = 8'hF1,
  parameter logic [7:0] CODE_OFF = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_data,
  input  logic [SRC_W-1:0] cmd_src,
  input  logic             port_en,
  input  logic             bcast,
  output logic             on_pulse,
  output logic             off_pulse,
  output logic             mode,
  output logic [NCPU-1:0]  smi_req
);
  cmd_kind_e       kind;
  logic [NCPU-1:0] target, smi_d;
  logic            on_d, off_d, mode_d;

  assign kind = classify(cmd_we, cmd_data, CODE_ON, CODE_OFF);

  for (genvar c = 0; c < NCPU; c++) begin : g_tgt
    assign target[c] = bcast || (cmd_src == SRC_W'(c));
  end

  always_comb begin
    on_d   = (kind == CMD_ON);
    off_d  = (kind == CMD_OFF);
    mode_d = mode;
    if (on_d)  mode_d = 1'b1;
    if (off_d) mode_d = 1'b0;
    smi_d  = (kind == CMD_SMI && port_en) ? target : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_pulse  <= 1'b0;
      off_pulse <= 1'b0;
      mode      <= 1'b0;
      smi_req   <= '0;
    end else begin
      on_pulse  <= on_d;
      off_pulse <= off_d;
      mode      <= mode_d;
      smi_req   <= smi_d;
    end
  end
endmodule

// File: rtl/smi_gate.sv
module smi_gate #(
  parameter int         NCPU      = 4,
  parameter int         FEAT_W    = 64,
  parameter int         BCAST_BIT = 0,
  parameter int         EN_W      = 8,
  parameter int         PM_W      = 8,
  parameter int         LOCK_BIT  = 4,
  parameter logic [7:0] CODE_ON   = 8'hF1,
  parameter logic [7:0] CODE_OFF  = 8'hF0,
  localparam int        SRC_W     = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int        BA_W      = $clog2(FEAT_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_data,
  input  logic [SRC_W-1:0]  cmd_src,
  input  logic [FEAT_W-1:0] host_feat,
  input  logic              req_we,
  input  logic [BA_W-1:0]   req_addr,
  input  logic [7:0]        req_data,
  input  logic              confirm_stb,
  input  logic              en_we,
  input  logic [EN_W-1:0]   en_wdata,
  input  logic              pm_we,
  input  logic [PM_W-1:0]   pm_wdata,
  output logic [EN_W-1:0]   smi_en_q,
  output logic [PM_W-1:0]   pmcon_q,
  output logic              acpi_on_pulse,
  output logic              acpi_off_pulse,
  output logic              acpi_mode,
  output logic [NCPU-1:0]   smi_req,
  output logic              feat_ok,
  output logic [FEAT_W-1:0] feat_neg
);
  smi_feat_negot #(.FEAT_W(FEAT_W), .BA_W(BA_W)) u_negot (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_addr(req_addr),
    .req_data(req_data), .confirm(confirm_stb), .host_feat(host_feat),
    .feat_ok(feat_ok), .feat_neg(feat_neg)
  );

  smi_ctl_regs #(.EN_W(EN_W), .PM_W(PM_W), .LOCK_BIT(LOCK_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
    .pm_we(pm_we), .pm_wdata(pm_wdata), .en_q(smi_en_q), .pm_q(pmcon_q)
  );

  smi_dispatch #(.NCPU(NCPU), .SRC_W(SRC_W), .CODE_ON(CODE_ON),
                 .CODE_OFF(CODE_OFF)) u_disp (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .cmd_src(cmd_src), .port_en(smi_en_q[0]), .bcast(feat_neg[BCAST_BIT]),
    .on_pulse(acpi_on_pulse), .off_pulse(acpi_off_pulse),
    .mode(acpi_mode), .smi_req(smi_req)
  );
endmodule

// File: rtl/smi_gate_chk.sv
module smi_gate_chk #(
  parameter int         NCPU      = 4,
  parameter int         FEAT_W    = 64,
  parameter int         BCAST_BIT = 0,
  parameter int         EN_W      = 8,
  parameter int         PM_W      = 8,
  parameter int         LOCK_BIT  = 4,
  parameter logic [7:0] CODE_ON   = 8'hF1,
  parameter logic [7:0] CODE_OFF  = 8'hF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic [7:0]        cmd_data,
  input logic [FEAT_W-1:0] host_feat,
  input logic [EN_W-1:0]   smi_en_q,
  input logic [PM_W-1:0]   pmcon_q,
  input logic              acpi_on_pulse,
  input logic              acpi_off_pulse,
  input logic [NCPU-1:0]   smi_req,
  input logic              feat_ok,
  input logic [FEAT_W-1:0] feat_neg
);
  logic acpi_code, smi_go;
  assign acpi_code = cmd_we && (cmd_data == CODE_ON || cmd_data == CODE_OFF);
  assign smi_go    = cmd_we && !acpi_code && smi_en_q[0];

  p_acpi_no_smi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acpi_code |=> (smi_req == '0));

  p_port_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !smi_en_q[0]) |=> (smi_req == '0));

  p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_go && !feat_neg[BCAST_BIT]) |=> ($countones(smi_req) == 1));

  p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_go && feat_neg[BCAST_BIT]) |=> (&smi_req));

  p_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok |-> ((feat_neg & ~host_feat) == '0));

  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok |=> (feat_ok && $stable(feat_neg)));

  p_pm_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pmcon_q[LOCK_BIT] |=> (pmcon_q[LOCK_BIT] && $stable(smi_en_q[0])));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> (smi_req == '0 && !acpi_on_pulse && !acpi_off_pulse));
endmodule

bind smi_gate smi_gate_chk #(
  .NCPU(NCPU), .FEAT_W(FEAT_W), .BCAST_BIT(BCAST_BIT), .EN_W(EN_W),
  .PM_W(PM_W), .LOCK_BIT(LOCK_BIT), .CODE_ON(CODE_ON), .CODE_OFF(CODE_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
  .host_feat(host_feat), .smi_en_q(smi_en_q), .pmcon_q(pmcon_q),
  .acpi_on_pulse(acpi_on_pulse), .acpi_off_pulse(acpi_off_pulse),
  .smi_req(smi_req), .feat_ok(feat_ok), .feat_neg(feat_neg)
);

// File: tb/sim_smi_gate.sv
module sim_smi_gate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we, req_we, confirm_stb, en_we, pm_we;
  logic [7:0]  cmd_data, req_data, en_wdata, pm_wdata;
  logic [1:0]  cmd_src;
  logic [2:0]  req_addr;
  logic [63:0] host_feat;
  logic [7:0]  smi_en_q, pmcon_q;
  logic        acpi_on_pulse, acpi_off_pulse, acpi_mode, feat_ok;
  logic [3:0]  smi_req;
  logic [63:0] feat_neg;

  int n_cmp = 0;
  int n_mis = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_gate u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .cmd_src(cmd_src), .host_feat(host_feat), .req_we(req_we),
    .req_addr(req_addr), .req_data(req_data), .confirm_stb(confirm_stb),
    .en_we(en_we), .en_wdata(en_wdata), .pm_we(pm_we), .pm_wdata(pm_wdata),
    .smi_en_q(smi_en_q), .pmcon_q(pmcon_q), .acpi_on_pulse(acpi_on_pulse),
    .acpi_off_pulse(acpi_off_pulse), .acpi_mode(acpi_mode),
    .smi_req(smi_req), .feat_ok(feat_ok), .feat_neg(feat_neg)
  );

  // en[39:32] src[31:24] cmd[23:16] smi[15:8] on[2] off[1] mode[0]
  localparam logic [39:0] VEC [8] = '{
    {8'h01, 8'd2, 8'hB2, 8'b0100, 5'b0, 3'b000},
    {8'h00, 8'd1, 8'hB2, 8'b0000, 5'b0, 3'b000},
    {8'h01, 8'd0, 8'hF1, 8'b0000, 5'b0, 3'b101},
    {8'h01, 8'd3, 8'h00, 8'b1000, 5'b0, 3'b001},
    {8'h01, 8'd1, 8'hF0, 8'b0000, 5'b0, 3'b010},
    {8'hFE, 8'd3, 8'h55, 8'b0000, 5'b0, 3'b000},
    {8'h01, 8'd1, 8'hFF, 8'b0010, 5'b0, 3'b000},
    {8'h00, 8'd0, 8'hF1, 8'b0000, 5'b0, 3'b101}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [7:0] d, input logic [1:0] s);
    @(negedge clk); cmd_we = 1'b1; cmd_data = d; cmd_src = s;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_en(input logic [7:0] d);
    @(negedge clk); en_we = 1'b1; en_wdata = d;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic wr_pm(input logic [7:0] d);
    @(negedge clk); pm_we = 1'b1; pm_wdata = d;
    @(negedge clk); pm_we = 1'b0;
  endtask

  task automatic wr_req(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); req_we = 1'b1; req_addr = a; req_data = d;
    @(negedge clk); req_we = 1'b0;
  endtask

  task automatic confirm();
    @(negedge clk); confirm_stb = 1'b1;
    @(negedge clk); confirm_stb = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    cmd_we = 0; req_we = 0; confirm_stb = 0; en_we = 0; pm_we = 0;
    cmd_data = 0; req_data = 0; en_wdata = 0; pm_wdata = 0;
    cmd_src = 0; req_addr = 0;
    host_feat = 64'h0100_0000_0000_0001;
    do_reset();

    // R9 reset state
    chk("R9 smi_req", 64'(smi_req), 64'h0);
    chk("R9 feat_ok", 64'(feat_ok), 64'h0);
    chk("R9 feat_neg", feat_neg, 64'h0);
    chk("R9 regs", {48'h0, smi_en_q, pmcon_q}, 64'h0);
    chk("R9 acpi", {61'h0, acpi_on_pulse, acpi_off_pulse, acpi_mode}, 64'h0);

    // vector table: single-target mode (R1 R2 R3 R11)
    for (int i = 0; i < 8; i++) begin
      wr_en(VEC[i][39:32]);
      wr_cmd(VEC[i][23:16], VEC[i][25:24]);
      chk("R2/R3 smi_req", 64'(smi_req), 64'(VEC[i][11:8]));
      chk("R1 acpi", {61'h0, acpi_on_pulse, acpi_off_pulse, acpi_mode},
          64'(VEC[i][2:0]));
      @(negedge clk);
      chk("R11 one-cycle", {59'h0, smi_req, acpi_on_pulse},
          64'h0);
    end

    // R5 refuse: bit 8 not supported
    wr_req(3'd0, 8'h01);
    wr_req(3'd7, 8'h01);
    wr_req(3'd1, 8'h01);
    confirm();
    chk("R5 feat_ok", 64'(feat_ok), 64'h0);
    chk("R5 feat_neg", feat_neg, 64'h0);

    // R6 R8 accept with little-endian lanes
    wr_req(3'd1, 8'h00);
    confirm();
    chk("R6 feat_ok", 64'(feat_ok), 64'h1);
    chk("R8 feat_neg", feat_neg, 64'h0100_0000_0000_0001);

    // R4 broadcast
    wr_en(8'h01);
    wr_cmd(8'h20, 2'd2);
    chk("R4 smi_req", 64'(smi_req), 64'hF);

    // R7 relock attempt
    wr_req(3'd0, 8'h00);
    wr_req(3'd7, 8'h00);
    confirm();
    chk("R7 feat_ok", 64'(feat_ok), 64'h1);
    chk("R7 feat_neg", feat_neg, 64'h0100_0000_0000_0001);

    // R10 lock
    wr_pm(8'h10);
    chk("R10 pmcon", 64'(pmcon_q), 64'h10);
    wr_en(8'h00);
    chk("R10 en bit0 held", 64'(smi_en_q), 64'h01);
    wr_en(8'hFE);
    chk("R10 en others", 64'(smi_en_q), 64'hFF);
    wr_pm(8'h0F);
    chk("R10 lock held", 64'(pmcon_q), 64'h1F);

    // R9 reset clears everything, including the request mask
    rst_n = 1'b0;
    host_feat = 64'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 feat after reset", {63'h0, feat_ok}, 64'h0);
    chk("R9 neg after reset", feat_neg, 64'h0);
    chk("R9 regs after reset", {48'h0, smi_en_q, pmcon_q}, 64'h0);
    confirm();
    chk("R9 request cleared", {63'h0, feat_ok}, 64'h1);
    chk("R9 neg empty", feat_neg, 64'h0);
    wr_en(8'h01);
    wr_en(8'h00);
    chk("R10 unlocked after reset", 64'(smi_en_q), 64'h0);
    wr_en(8'h01);
    wr_cmd(8'h33, 2'd1);
    chk("R3 single after reset", 64'(smi_req), 64'h2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule